// File: doc/BRIEF.md
# Half to single precision widener

This block turns a 16-bit IEEE 754 half-precision bit pattern into the 32-bit single-precision bit pattern with the same value. It works only on bits. It uses no floating-point arithmetic and needs no rounding, because every half value fits exactly in single precision. It handles every input class: signed zeros, subnormals, normals, infinities and NaNs.

Subnormal half inputs are renormalised. The block finds the leading one of the mantissa and shifts it into the hidden-bit position. It then lowers the exponent by the same amount, so no result is ever a single-precision subnormal.

A parameter selects one of two variants. One is a purely combinational path. The other has one output register, where a valid strobe travels alongside the data. In the registered variant, the data register loads only when the input strobe is high.

Top module: `hp_to_sp_widen`

## Requirements
- R1: Output bit 31 equals input bit 15 for every input code, including zeros, infinities and NaNs.
- R2: For a normal input (biased exponent 1 to 30), the output exponent field (bits 30:23) equals the input exponent (bits 14:10) plus 112.
- R3: For a normal input, the output bits 22:13 equal the input mantissa (bits 9:0), and the output bits 12:0 are zero.
- R4: An input exponent of 31 gives an output exponent of 0xFF, with output bits 22:13 equal to the input mantissa and bits 12:0 zero. A zero mantissa therefore stays infinity, and a non-zero mantissa stays NaN with its payload.
- R5: An input with bits 14:0 all zero gives an output with bits 30:0 all zero. The sign is kept.
- R6: For a subnormal input (exponent 0, mantissa non-zero), let p be the bit position of the highest set mantissa bit (0 to 9). The output exponent is 103 + p. Output bits 22:13 hold the mantissa shifted left by 10 - p, with the leading one dropped, and bits 12:0 are zero.
- R7: The output exponent field is never 0 while the output bits 22:0 are non-zero. Input 0x0001 gives 0x33800000 and input 0x03FF gives 0x387FC000.
- R8: With the output register enabled, `out_valid` equals `in_valid` delayed by exactly one clock, and `out_single` holds the conversion of the word presented with that strobe. With the register disabled, both outputs follow the inputs within the same cycle.
- R9: A synchronous active-high `rst` clears `out_valid` at the next clock edge.
- R10: With the output register enabled, a clock edge where `in_valid` is low leaves `out_single` unchanged, whatever `in_half` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (used only when the output register is enabled) |
| rst | input | 1 | Synchronous active-high reset of the output strobe |
| in_valid | input | 1 | Input word qualifier |
| in_half | input | 16 | Half-precision bit pattern |
| out_valid | output | 1 | Output word qualifier |
| out_single | output | 32 | Single-precision bit pattern |

## Verification
The block holds no state beyond the output register. A wrong shift count or a wrong exponent offset therefore shows in `out_single` on the clock right after the faulty code is presented, and only for the affected input class. For that reason, every one of the 65536 input codes is presented and checked against a reference model that normalises by iterating. A strobe or reset fault shows in `out_valid` one edge after the stimulus. A faulty load enable shows as a changed `out_single` after an edge where `in_valid` was low.

// File: rtl/hp_to_sp_widen.sv
module hp_to_sp_widen #(
  parameter bit OUT_REG = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic [15:0] in_half,
  output logic        out_valid,
  output logic [31:0] out_single
);

  localparam int HEXP    = 5;
  localparam int HMAN    = 10;
  localparam int SEXP    = 8;
  localparam int SMAN    = 23;
  localparam int PAD     = SMAN - HMAN;
  localparam int ADJ     = 127 - 15;
  localparam int SUB_BASE = ADJ + 1 - HMAN;

  logic            sgn;
  logic [HEXP-1:0] exp_h;
  logic [HMAN-1:0] man_h;
  logic [3:0]      lead;
  logic [3:0]      shamt;
  logic [HMAN-1:0] man_n;
  logic [SEXP-1:0] exp_s;
  logic [HMAN-1:0] man_s;
  logic [31:0]     res;

  assign sgn   = in_half[15];
  assign exp_h = in_half[14:10];
  assign man_h = in_half[9:0];

  always_comb begin
    lead = '0;
    for (int i = 0; i < HMAN; i++)
      if (man_h[i]) lead = 4'(i);
  end

  assign shamt = 4'(HMAN) - lead;
  assign man_n = man_h << shamt;

  always_comb begin
    if (&exp_h) begin
      exp_s = '1;
      man_s = man_h;
    end else if (exp_h != '0) begin
      exp_s = SEXP'(exp_h) + SEXP'(ADJ);
      man_s = man_h;
    end else if (man_h != '0) begin
      exp_s = SEXP'(SUB_BASE) + SEXP'(lead);
      man_s = man_n;
    end else begin
      exp_s = '0;
      man_s = '0;
    end
  end

  assign res = {sgn, exp_s, man_s, {PAD{1'b0}}};

  always_comb begin
    if (in_valid == 1'b1) begin
      AST_NO_SUBNORM: assert (res[30:23] != '0 || res[22:0] == '0) else $error("subnormal output"); // R7
      AST_SPECIAL_EXP: assert (!(&exp_h) || res[30:23] == 8'hFF) else $error("inf/nan exponent"); // R4
      AST_ZERO_MAG: assert (in_half[14:0] != '0 || res[30:0] == '0) else $error("zero magnitude"); // R5
    end
  end

  generate
    if (OUT_REG) begin : g_reg
      logic        v_q;
      logic [31:0] d_q;

      always_ff @(posedge clk) begin
        if (rst) v_q <= 1'b0;
        else     v_q <= in_valid;
        if (in_valid) d_q <= res;
      end

      assign out_valid  = v_q;
      assign out_single = d_q;

      AST_RST_CLEAR: assert property (@(posedge clk) rst |=> !out_valid) else $error("reset"); // R9
      AST_VALID_FOLLOW: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid) else $error("valid rise"); // R8
      AST_VALID_DROP: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_valid) else $error("valid drop"); // R8
      AST_SIGN_PASS: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_single[31] == $past(in_half[15])) else $error("sign"); // R1
      AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst) !in_valid |=> $stable(out_single)) else $error("hold"); // R10
    end else begin : g_comb
      assign out_valid  = in_valid;
      assign out_single = res;
    end
  endgenerate

endmodule

// File: tb/hp_to_sp_widen_test.sv
module hp_to_sp_widen_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] in_half = 16'h0;
  logic        out_valid, c_valid;
  logic [31:0] out_single, c_single;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  hp_to_sp_widen #(.OUT_REG(1'b1)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_half(in_half),
    .out_valid(out_valid), .out_single(out_single));

  hp_to_sp_widen #(.OUT_REG(1'b0)) uut_comb (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_half(in_half),
    .out_valid(c_valid), .out_single(c_single));

  localparam int NV = 14;
  localparam logic [47:0] VEC [NV] = '{
    {16'h3C00, 32'h3F800000}, {16'hBC00, 32'hBF800000},
    {16'h7BFF, 32'h477FE000}, {16'h0400, 32'h38800000},
    {16'h7C00, 32'h7F800000}, {16'hFC00, 32'hFF800000},
    {16'h7E00, 32'h7FC00000}, {16'h7C01, 32'h7F802000},
    {16'h0000, 32'h00000000}, {16'h8000, 32'h80000000},
    {16'h0001, 32'h33800000}, {16'h03FF, 32'h387FC000},
    {16'h8200, 32'hB8000000}, {16'h3555, 32'h3EAAA000}};
  localparam string VTAG [NV] = '{"R2", "R1", "R3", "R2", "R4", "R4", "R4",
                                  "R4", "R5", "R5", "R7", "R7", "R6", "R3"};

  function automatic logic [31:0] ref_conv(input logic [15:0] h);
    logic [10:0] mm;
    int ex;
    if (h[14:10] == 5'h1F) return {h[15], 8'hFF, h[9:0], 13'h0};
    if (h[14:0] == 15'h0) return {h[15], 31'h0};
    if (h[14:10] != 5'h0) begin
      ex = int'(h[14:10]) + 112;
      return {h[15], ex[7:0], h[9:0], 13'h0};
    end
    mm = {1'b0, h[9:0]};
    ex = 113;
    while (!mm[10]) begin
      mm = mm << 1;
      ex = ex - 1;
    end
    return {h[15], ex[7:0], mm[9:0], 13'h0};
  endfunction

  function automatic string tag_of(input logic [15:0] h);
    if (h[14:10] == 5'h1F) return "R4";
    if (h[14:0] == 15'h0) return "R5";
    if (h[14:10] == 5'h0) return "R6";
    return "R2";
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      finish_run();
    end
  end

  initial begin
    @(negedge clk);
    @(posedge clk); #1;
    check("R9 reset", {31'h0, out_valid}, 32'h0);
    @(negedge clk) rst = 1'b0;

    // R8 latency: strobe visible one edge later, gone one edge after dropping
    @(negedge clk) begin in_valid = 1'b1; in_half = 16'h3C00; end
    #1 check("R8 comb path", c_single, 32'h3F800000);
    check("R8 before edge", {31'h0, out_valid}, 32'h0);
    @(posedge clk); #1;
    check("R8 valid one cycle", {31'h0, out_valid}, 32'h1);
    check("R8 data", out_single, 32'h3F800000);
    @(negedge clk) begin in_valid = 1'b0; in_half = 16'h7C00; end
    @(posedge clk); #1;
    check("R8 valid drop", {31'h0, out_valid}, 32'h0);
    check("R10 hold idle", out_single, 32'h3F800000);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk) begin in_valid = 1'b1; in_half = VEC[i][47:32]; end
      #1 check({VTAG[i], " comb"}, c_single, VEC[i][31:0]);
      @(posedge clk); #1;
      check(VTAG[i], out_single, VEC[i][31:0]);
    end

    for (int c = 0; c < 65536; c++) begin
      @(negedge clk) begin in_valid = 1'b1; in_half = 16'(c); end
      @(posedge clk); #1;
      check(tag_of(16'(c)), out_single, ref_conv(16'(c)));
      if (out_single[31] !== in_half[15]) check("R1 sign", {31'h0, out_single[31]}, {31'h0, in_half[15]});
      if (out_single[30:23] == 8'h0 && out_single[22:0] != 23'h0) check("R7 subnormal", out_single, 32'h0);
    end

    // R9 reset while strobe high
    @(negedge clk) rst = 1'b1;
    @(posedge clk); #1;
    check("R9 reset with valid", {31'h0, out_valid}, 32'h0);
    @(negedge clk) begin rst = 1'b0; in_valid = 1'b0; end
    @(posedge clk); #1;
    finish_run();
  end

endmodule